// File: doc/BRIEF.md
# Converter Clock Divider with Asymmetric Duty and Queue Trigger Timer

This block derives the clock for an analog-to-digital converter from the system clock. Software sets the length of the clock's high phase and the length of its low phase separately, so the duty cycle can be uneven and the period can be tuned to keep conversion time close to its limit whatever the system frequency is. A 5-bit field sets the high time and a 3-bit field sets the low time. Each phase lasts one system cycle more than its field value, so the divide ratio runs from 2 to 40.

A new divide setting is never applied in the middle of a conversion. A write goes into a pending holding register. It becomes the active setting only at the start of a converter-clock high phase, and only while both conversion queues report that they are disabled.

A free-running binary counter advances once per converter-clock period. A 4-bit select field picks one of its bits 7 through 17 as a tap. Each rising edge of the selected tap sends a one-cycle trigger pulse to both conversion queues. This pulse serves as the periodic or interval event that starts queued conversions.

Top module: `adc_clk_prescaler`

## Requirements
- R1: With an active high-time field value h (0..31), every high phase of `conv_clk` lasts exactly h+1 system cycles.
- R2: With an active low-time field value l (0..7), every low phase of `conv_clk` lasts exactly l+1 system cycles, so the period is h+l+2 cycles (2 to 40).
- R3: Synchronous active-high reset drives `conv_clk` low, clears the trigger timer and outputs, and makes h=0, l=0 active. The first edge after reset is released drives `conv_clk` high, and the clock then toggles every cycle.
- R4: A divide setting written while `q1_idle` or `q2_idle` is 0 does not change the `conv_clk` waveform while that queue stays active.
- R5: A pending setting becomes active on the first low-to-high transition of `conv_clk` at which both `q1_idle` and `q2_idle` are 1. The high phase that starts at that transition already uses the new high time.
- R6: A second write made before a pending setting is applied replaces it. Only the last written values ever become active.
- R7: The trigger timer increments once per `conv_clk` rising edge. `tap_sel` = k (0..10) selects timer bit 7+k. On each 0-to-1 change of that bit, `q1_trig` pulses high for exactly one system cycle, beginning the second system edge after the `conv_clk` rise that set the bit.
- R8: `q1_trig` and `q2_trig` are always equal.
- R9: When `tap_sel` is 11 to 15, no trigger pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a new divide setting |
| cfg_high | input | 5 | High-time field (phase length minus one) |
| cfg_low | input | 3 | Low-time field (phase length minus one) |
| q1_idle | input | 1 | Queue 1 is in a disabled mode |
| q2_idle | input | 1 | Queue 2 is in a disabled mode |
| tap_sel | input | 4 | Timer tap select, 0..10 picks bit 7..17 |
| conv_clk | output | 1 | Divided converter clock |
| q1_trig | output | 1 | Periodic trigger pulse to queue 1 |
| q2_trig | output | 1 | Periodic trigger pulse to queue 2 |

## Verification
The bench measures both phase lengths at the minimum divide after reset and at the maximum of 32 plus 8 cycles. A design that used the field value directly as the cycle count, without adding one, would fail here, either with one-cycle-short phases or by stalling on a zero field. It writes while queue 1 is active and checks that the waveform does not change. A design that ignored the gating would change its period in the middle of a conversion. It overwrites a held setting before releasing the queues, which catches a design that keeps the first write. A cycle-accurate model, compared on every clock, catches a new high time applied one phase late, a trigger that lasts more than one cycle or starts one cycle off, and a trigger that still fires when the tap select is out of range.

// File: rtl/adc_presc_pkg.sv
package adc_presc_pkg;
    localparam int HI_W = 5;
    localparam int LO_W = 3;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } div_cfg_t;
endpackage

// File: rtl/presc_cfg.sv
module presc_cfg
    import adc_presc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  div_cfg_t wr_cfg,
    input  logic     q1_off,
    input  logic     q2_off,
    input  logic     at_rise,
    output div_cfg_t cfg_nxt
);
    typedef struct packed {
        div_cfg_t act;
        div_cfg_t pend;
        logic     pend_v;
    } cfg_st_t;

    cfg_st_t s_d, s_q;
    logic    apply;

    always_comb begin
        s_d   = s_q;
        apply = at_rise && s_q.pend_v && q1_off && q2_off;
        if (apply) begin
            s_d.act    = s_q.pend;
            s_d.pend_v = 1'b0;
        end
        if (wr_en) begin
            s_d.pend   = wr_cfg;
            s_d.pend_v = 1'b1;
        end
        cfg_nxt = s_d.act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // The active setting moves only at a rising boundary with both queues off
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(at_rise && q1_off && q2_off) |=> $stable(s_q.act));

    // A write always leaves a setting pending on the next cycle
    assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (s_q.pend_v && s_q.pend == $past(wr_cfg)));
endmodule

// File: rtl/presc_phase.sv
module presc_phase
    import adc_presc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg_nxt,
    output logic     clk_out,
    output logic     at_rise
);
    typedef struct packed {
        logic [HI_W-1:0] cnt;
        logic            lvl;
    } ph_st_t;

    ph_st_t s_d, s_q;
    logic   cnt_zero;

    always_comb begin
        s_d      = s_q;
        cnt_zero = (s_q.cnt == '0);
        if (cnt_zero) begin
            s_d.lvl = ~s_q.lvl;
            if (s_q.lvl) begin
                s_d.cnt = HI_W'(cfg_nxt.lo);
            end else begin
                s_d.cnt = cfg_nxt.hi;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        at_rise = cnt_zero && !s_q.lvl;
        clk_out = s_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Inside a phase the counter steps down by one and the level holds
    assert_phase_count_R1: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt != '0) |=> ($stable(s_q.lvl) && s_q.cnt == $past(s_q.cnt) - 1'b1));

    // The low phase never loads a count beyond the 3-bit field range
    assert_low_range_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(s_q.lvl) |-> (s_q.cnt < HI_W'(1 << LO_W)));
endmodule

// File: rtl/presc_tap_timer.sv
module presc_tap_timer #(
    parameter int TAP_BASE = 7,
    parameter int TAP_NUM  = 11,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             trig
);
    localparam int TMR_W = TAP_BASE + TAP_NUM;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             prev;
        logic             trig;
    } tm_st_t;

    tm_st_t s_d, s_q;
    logic   tap_now;

    always_comb begin
        tap_now = 1'b0;
        for (int k = 0; k < TAP_NUM; k++) begin
            if (tap_sel == SEL_W'(k)) begin
                tap_now = s_q.tmr[TAP_BASE + k];
            end
        end
        s_d      = s_q;
        s_d.prev = tap_now;
        s_d.trig = tap_now && !s_q.prev;
        if (step) begin
            s_d.tmr = s_q.tmr + 1'b1;
        end
        trig = s_q.trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Trigger is a single-cycle pulse
    assert_trig_single_R7: assert property (@(posedge clk) disable iff (rst)
        s_q.trig |=> !s_q.trig);

    // Timer only moves on a converter clock rise
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(s_q.tmr));

    // Out-of-range select yields no trigger
    assert_tap_off_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(tap_sel) >= TAP_NUM) |=> !s_q.trig);
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
    import adc_presc_pkg::*;
#(
    parameter int TAP_BASE = 7,
    parameter int TAP_NUM  = 11,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [HI_W-1:0]  cfg_high,
    input  logic [LO_W-1:0]  cfg_low,
    input  logic             q1_idle,
    input  logic             q2_idle,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             conv_clk,
    output logic             q1_trig,
    output logic             q2_trig
);
    div_cfg_t wr_cfg;
    div_cfg_t cfg_nxt;
    logic     at_rise;
    logic     trig;

    assign wr_cfg = '{hi: cfg_high, lo: cfg_low};

    presc_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_cfg  (wr_cfg),
        .q1_off  (q1_idle),
        .q2_off  (q2_idle),
        .at_rise (at_rise),
        .cfg_nxt (cfg_nxt)
    );

    presc_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .cfg_nxt (cfg_nxt),
        .clk_out (conv_clk),
        .at_rise (at_rise)
    );

    presc_tap_timer #(
        .TAP_BASE (TAP_BASE),
        .TAP_NUM  (TAP_NUM),
        .SEL_W    (SEL_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .step    (at_rise),
        .tap_sel (tap_sel),
        .trig    (trig)
    );

    assign q1_trig = trig;
    assign q2_trig = trig;

    // Both queues see the same event
    assert_trig_pair_R8: assert property (@(posedge clk) disable iff (rst)
        q1_trig == q2_trig);

    // Reset leaves the clock low on the first free cycle
    assert_reset_low_R3: assert property (@(posedge clk)
        rst |=> !conv_clk);
endmodule

// File: tb/tb_adc_clk_prescaler.sv
module tb_adc_clk_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_high = '0;
    logic [2:0] cfg_low = '0;
    logic       q1_idle = 1'b1;
    logic       q2_idle = 1'b1;
    logic [3:0] tap_sel = 4'd0;
    logic       conv_clk, q1_trig, q2_trig;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    adc_clk_prescaler dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_high(cfg_high),
        .cfg_low(cfg_low), .q1_idle(q1_idle), .q2_idle(q2_idle),
        .tap_sel(tap_sel), .conv_clk(conv_clk), .q1_trig(q1_trig),
        .q2_trig(q2_trig)
    );

    // Behavioural reference: remaining cycles per phase, plain integers
    int  m_rem, m_timer, a_hi, a_lo, p_hi, p_lo;
    bit  m_out, m_prev, m_trig, p_v, m_up, m_tap;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_out = 0; m_rem = 1; m_timer = 0; m_prev = 0; m_trig = 0;
            a_hi = 0; a_lo = 0; p_v = 0; p_hi = 0; p_lo = 0;
        end else begin
            m_up = (!m_out && m_rem == 1);
            if (m_up && p_v && q1_idle && q2_idle) begin
                a_hi = p_hi; a_lo = p_lo; p_v = 0;
            end
            m_tap  = (tap_sel < 11) ? (((m_timer >> (7 + int'(tap_sel))) & 1) == 1) : 1'b0;
            m_trig = m_tap && !m_prev;
            m_prev = m_tap;
            if (m_rem == 1) begin
                m_out = !m_out;
                m_rem = m_out ? a_hi + 1 : a_lo + 1;
                if (m_out) m_timer++;
            end else begin
                m_rem--;
            end
            if (cfg_wr) begin
                p_hi = int'(cfg_high); p_lo = int'(cfg_low); p_v = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check(conv_clk == m_out, "R1 R2 R5 conv_clk", int'(conv_clk), int'(m_out));
        check(q1_trig == m_trig, "R7 q1_trig", int'(q1_trig), int'(m_trig));
        check(q2_trig == q1_trig, "R8 q2_trig", int'(q2_trig), int'(q1_trig));
    end

    task automatic measure(output int hl, output int ll);
        hl = 0; ll = 0;
        @(negedge clk);
        while (conv_clk) @(negedge clk);
        while (!conv_clk) @(negedge clk);
        while (conv_clk) begin hl++; @(negedge clk); end
        while (!conv_clk) begin ll++; @(negedge clk); end
    endtask

    task automatic write_cfg(input int h, input int l);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_high = 5'(h); cfg_low = 3'(l);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic expect_div(input int h, input int l, input string req);
        int hl, ll;
        measure(hl, ll);
        measure(hl, ll);
        check(hl == h + 1, req, hl, h + 1);
        check(ll == l + 1, req, ll, l + 1);
    endtask

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        check(conv_clk == 1'b0, "R3 clk low in reset", int'(conv_clk), 0);
        check(q1_trig == 1'b0, "R3 trig low in reset", int'(q1_trig), 0);
        rst = 1'b0;
        @(negedge clk);
        check(conv_clk == 1'b1, "R3 first edge high", int'(conv_clk), 1);
        expect_div(0, 0, "R3 min divide");

        write_cfg(4, 2);
        expect_div(4, 2, "R1 R2 asym 4/2");

        q1_idle = 1'b0;
        write_cfg(31, 7);
        expect_div(4, 2, "R4 held while q1 active");
        write_cfg(2, 0);
        expect_div(4, 2, "R4 still held");
        q1_idle = 1'b1;
        expect_div(2, 0, "R6 last write wins R5");

        write_cfg(31, 7);
        expect_div(31, 7, "R5 max divide 40");
        q2_idle = 1'b0;
        write_cfg(0, 0);
        expect_div(31, 7, "R4 held while q2 active");
        q2_idle = 1'b1;
        expect_div(0, 0, "R5 back to min");

        tap_sel = 4'd0;
        pulses = 0;
        repeat (3000) begin
            @(negedge clk);
            if (q1_trig) pulses++;
        end
        check(pulses >= 2, "R7 tap 0 pulses", pulses, 2);

        tap_sel = 4'd13;
        repeat (3) @(negedge clk);
        pulses = 0;
        repeat (1500) begin
            @(negedge clk);
            if (q1_trig) pulses++;
        end
        check(pulses == 0, "R9 tap 13 silent", pulses, 0);

        tap_sel = 4'd1;
        repeat (2500) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule